// File: doc/BRIEF.md
# Byte Parity Error Monitor

This block sits beside a byte-wide memory array and guards it with one parity bit per byte. On each write it produces the check bit that the array stores beside the byte. On each read it takes the byte and its stored check bit back, recomputes the parity and compares the two. When they disagree, it sets an error flag that stays set.

The flag stays set until software writes to the clear port, or until reset. While the flag is set, the block lights an indicator. It can also pull either of two active-low bus lines, an NMI line and a bus error line. Each line has its own enable. When the flag is set by the first error, the block records the address of the failing read. That address is not replaced by later errors until the flag is cleared.

Top module: `parity_err_monitor`

## Requirements
- R1: `wr_par` is the even-parity bit of `wr_data`, meaning the XOR of its 8 bits, and is available combinationally in the same cycle as `wr_en`.
- R2: A read (`rd_en`=1) whose recomputed XOR of `rd_data` differs from `rd_par` sets `err_flag` at the next rising clock edge.
- R3: A read whose parity matches, or a cycle with `rd_en`=0, never sets `err_flag`.
- R4: `err_flag` stays set until a clear. A clear is a cycle with `io_wr`=1 and `io_addr[1:0]`=2'b10, and it drops the flag at the next edge. An I/O write with any other value of `io_addr[1:0]` has no effect.
- R5: When a clear and a failing read happen in the same cycle, the flag stays set at the next edge.
- R6: `err_led` is high exactly when `err_flag` is high.
- R7: `nmi_n` is low only while `err_flag`=1 and `nmi_route`=1. Otherwise it is high.
- R8: `buserr_n` is low only while `err_flag`=1 and `err_route`=1. Otherwise it is high.
- R9: `err_addr` takes the address of the failing read only when the flag was clear before that read. While the flag stays set, later errors leave `err_addr` unchanged.
- R10: A synchronous active-high `rst` clears `err_flag` and `err_addr` and releases both bus lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | memory write strobe |
| wr_data | input | 8 | byte being written |
| wr_par | output | 1 | check bit to store |
| rd_en | input | 1 | memory read strobe |
| rd_data | input | 8 | byte read back |
| rd_par | input | 1 | stored check bit |
| rd_addr | input | ADDR_W | address of the read |
| io_wr | input | 1 | I/O port write strobe |
| io_addr | input | 8 | I/O port address |
| nmi_route | input | 1 | route the error to the NMI line |
| err_route | input | 1 | route the error to the bus error line |
| err_flag | output | 1 | sticky error flag |
| err_led | output | 1 | indicator drive |
| nmi_n | output | 1 | active-low NMI request |
| buserr_n | output | 1 | active-low bus error request |
| err_addr | output | ADDR_W | address of the first failing read |

## Verification
On every cycle, the assertions check the following:
- how the flag moves between set and clear in response to failing reads and decoded clears, including a clear that lands in the same cycle as an error;
- that the indicator and the two bus lines follow the flag and their enables;
- that the captured address stays frozen while the flag is set.

Only the bench's scenarios show that the check bit matches independently computed parity across many random bytes. They also show that non-decoded port writes leave a set flag visible at the pins, and that the right address is the one held after a run of several errors.

// File: rtl/parity_mon_pkg.sv
package parity_mon_pkg;
  localparam int DATA_W = 8;
  localparam logic [1:0] CLR_PORT_SEL = 2'b10;
endpackage

// File: rtl/parity_gen.sv
module parity_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  output logic         par
);
  always_comb par = ^data;
endmodule

// File: rtl/err_latch.sv
module err_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_hit,
  input  logic              clr_hit,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              flag,
  output logic [ADDR_W-1:0] cap_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      cap_addr <= '0;
    end else begin
      if (err_hit)      flag <= 1'b1;
      else if (clr_hit) flag <= 1'b0;
      if (err_hit && !flag) cap_addr <= hit_addr;
    end
  end

  AST_SET_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    err_hit |=> flag); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_hit) |=> flag); // R4
  AST_NO_SPUR: assert property (@(posedge clk) disable iff (rst)
    (!flag && !err_hit) |=> !flag); // R3
  AST_CLR_DROP: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !err_hit) |=> !flag); // R4
  AST_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && err_hit) |=> flag); // R5
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    flag |=> $stable(cap_addr)); // R9
endmodule

// File: rtl/err_route.sv
module err_route (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic nmi_en,
  input  logic bus_en,
  output logic led,
  output logic nmi_n,
  output logic bus_n
);
  always_comb begin
    led   = flag;
    nmi_n = ~(flag & nmi_en);
    bus_n = ~(flag & bus_en);
  end

  AST_LED: assert property (@(posedge clk) disable iff (rst) led == flag); // R6
  AST_NMI: assert property (@(posedge clk) disable iff (rst)
    !nmi_n |-> (flag && nmi_en)); // R7
  AST_BUS: assert property (@(posedge clk) disable iff (rst)
    !bus_n |-> (flag && bus_en)); // R8
endmodule

// File: rtl/parity_err_monitor.sv
module parity_err_monitor
  import parity_mon_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              wr_par,
  input  logic              rd_en,
  input  logic [7:0]        rd_data,
  input  logic              rd_par,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic              nmi_route,
  input  logic              err_route,
  output logic              err_flag,
  output logic              err_led,
  output logic              nmi_n,
  output logic              buserr_n,
  output logic [ADDR_W-1:0] err_addr
);
  logic rd_calc, err_hit, clr_hit, wr_unused;

  parity_gen #(.W(DATA_W)) u_wgen (.data(wr_data), .par(wr_par));
  parity_gen #(.W(DATA_W)) u_rgen (.data(rd_data), .par(rd_calc));

  assign wr_unused = wr_en;
  assign err_hit   = rd_en && (rd_calc != rd_par);
  assign clr_hit   = io_wr && (io_addr[1:0] == CLR_PORT_SEL);

  err_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .err_hit(err_hit), .clr_hit(clr_hit),
    .hit_addr(rd_addr), .flag(err_flag), .cap_addr(err_addr));

  err_route u_route (
    .clk(clk), .rst(rst), .flag(err_flag), .nmi_en(nmi_route),
    .bus_en(err_route), .led(err_led), .nmi_n(nmi_n), .bus_n(buserr_n));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!err_flag && nmi_n && buserr_n)); // R10
endmodule

// File: tb/parity_err_monitor_bench.sv
module parity_err_monitor_bench;
  localparam int AW = 16;
  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, rd_par = 0, io_wr = 0, nmi_route = 0, err_route = 0;
  logic [7:0] wr_data = 0, rd_data = 0, io_addr = 0;
  logic [AW-1:0] rd_addr = 0;
  logic wr_par, err_flag, err_led, nmi_n, buserr_n;
  logic [AW-1:0] err_addr;
  int checks = 0, fails = 0;
  bit exp_flag = 0;
  logic [AW-1:0] exp_addr = 0;

  always #4 clk = ~clk;

  parity_err_monitor #(.ADDR_W(AW)) u_parity_err_monitor (.*);

  function automatic bit ref_par(input logic [7:0] d);
    bit p = 0;
    for (int i = 0; i < 8; i++) p ^= d[i];
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    chk({req, " flag"}, err_flag, exp_flag);
    chk("R6 led", err_led, exp_flag);
    chk("R7 nmi", nmi_n, !(exp_flag && nmi_route));
    chk("R8 buserr", buserr_n, !(exp_flag && err_route));
    chk("R9 addr", err_addr, exp_addr);
  endtask

  // drive one cycle of stimulus; update model; check after edge
  task automatic cyc(input bit rd, input bit bad, input logic [AW-1:0] a,
                     input bit iow, input logic [7:0] ia, input string req);
    bit e, c;
    @(negedge clk);
    rd_en = rd; rd_addr = a; rd_data = 8'($urandom);
    rd_par = ref_par(rd_data) ^ bad;
    io_wr = iow; io_addr = ia;
    e = rd && bad; c = iow && (ia[1:0] == 2'b10);
    if (e && !exp_flag) exp_addr = a;
    if (e) exp_flag = 1; else if (c) exp_flag = 0;
    @(negedge clk);
    rd_en = 0; io_wr = 0;
    check_outs(req);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    check_outs("R10 reset");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wr_en = 1; wr_data = 8'($urandom);
      #1 chk("R1 wr_par", wr_par, ref_par(wr_data));
    end
    wr_en = 0;
    nmi_route = 1; err_route = 0;
    cyc(1, 0, 16'h0100, 0, 0, "R3 good read");
    cyc(0, 1, 16'h0101, 0, 0, "R3 rd_en low");
    cyc(1, 1, 16'h1234, 0, 0, "R2 bad read");
    cyc(1, 1, 16'h5678, 0, 0, "R9 second err");
    cyc(0, 0, 0, 1, 8'hF1, "R4 non-decoded port");
    cyc(0, 0, 0, 1, 8'hF3, "R4 non-decoded port");
    cyc(0, 0, 0, 1, 8'h02, "R4 clear");
    err_route = 1; nmi_route = 0;
    cyc(1, 1, 16'hABCD, 0, 0, "R2 bad read");
    cyc(1, 1, 16'h1111, 1, 8'h06, "R5 clear with error");
    cyc(0, 0, 0, 1, 8'h06, "R4 clear");
    for (int i = 0; i < 300; i++) begin
      nmi_route = 1'($urandom); err_route = 1'($urandom);
      cyc(1'($urandom), ($urandom % 5) == 0, 16'($urandom),
          ($urandom % 6) == 0, 8'($urandom), "R2 random");
    end
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    exp_flag = 0; exp_addr = 0;
    check_outs("R10 reset again");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule